// File: doc/BRIEF.md
# Serial Chain Length Discovery and Node Select Controller

This controller sits on the master side of a serial chain built from identical downstream nodes. Every node holds the same number of shift-register bits and passes its last bit on to the next node. The controller produces the shift clock, the serial data and a latch strobe. It can learn how many nodes are attached, and it can load a select pattern that enables any set of those nodes.

A discover command first clears the chain. It shifts zeros for one clock more than the longest possible chain, then checks that the sensed line is at its idle level. Next it sends a marker and counts shift clock edges until the marker shows up. In return mode the sensed line is the data coming back from the far end of the chain, and ones are shifted until a one comes back. In acknowledge mode the sensed line is a shared wired line that stays low while any node bit is set. A single one is pushed in, and the controller counts edges until the line goes high again. Dividing the edge count by the bits per node gives the node count.

A select command shifts one level per node, with the data for the farthest node going first. Each level is the node's select bit XOR its polarity bit. One latch pulse follows, so node outputs change only at that moment.

Top module: `daisy_master`

## Requirements
- R1: Under reset and in the first idle cycle after it, `sck`, `sdo`, `latch`, `busy`, `done`, `node_count`, `timeout_err` and `stuck_err` are all 0.
- R2: A discover first drives `sdo` low for FLUSH_LEN = MAX_NODES*NODE_BITS+1 rising shift clock edges. This clears any earlier contents of a chain of up to MAX_NODES nodes.
- R3: In return mode (`ack_mode`=0), if the first one arrives on `ret_in` after B rising edges of the marker phase, `node_count` = B/NODE_BITS. The total number of rising edges is FLUSH_LEN+B. Chains of 0 to MAX_NODES nodes (MAX_NODES is at least 16) are counted.
- R4: In acknowledge mode (`ack_mode`=1), a single one is shifted in. If `ack_in` first reads high after edge B+1, then `node_count` = B/NODE_BITS and the operation uses FLUSH_LEN+B+1 rising edges.
- R5: If after the flush the sensed line is not at idle (`ret_in` high in return mode, `ack_in` low in acknowledge mode), discovery ends with `stuck_err`=1, `timeout_err`=0 and `node_count`=0, after exactly FLUSH_LEN edges.
- R6: If no marker is seen by the edge limit (MAX_NODES*NODE_BITS in return mode), discovery ends with `timeout_err`=1, `stuck_err`=0 and `node_count`=0.
- R7: After a select, node k (k=0 is nearest the master) holds `sel_pattern[k]` XOR `sel_polarity[k]` in all of its bits. Any number of nodes may be enabled together. Exactly MAX_NODES*NODE_BITS rising edges are used.
- R8: `latch` is a single-cycle pulse. It comes exactly once per select, after the last shift edge, with `sck` low. No latch pulse occurs during a discover.
- R9: `sck` has a period of 2*HALF_DIV system clocks and is low whenever the block is idle. `sdo` changes only while `sck` is low.
- R10: `done` is a one-cycle pulse in the first idle cycle after an operation. `busy` is high from the cycle after an accepted command until then. Commands that arrive while busy are ignored. When both commands arrive in the same idle cycle, discover wins.
- R11: `node_count`, `timeout_err` and `stuck_err` change only when a discover completes. A select leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| disc_req | input | 1 | Start a discover (single cycle, taken when idle) |
| sel_req | input | 1 | Start a select (single cycle, taken when idle) |
| ack_mode | input | 1 | Sensing mode for discover: 0 return line, 1 acknowledge line |
| sel_pattern | input | MAX_NODES | Select bit per node, bit k for node k |
| sel_polarity | input | MAX_NODES | Per node polarity, 1 inverts the level shifted to that node |
| ret_in | input | 1 | Data returning from the end of the chain (asynchronous) |
| ack_in | input | 1 | Shared acknowledge line, low while any node bit is set (asynchronous) |
| sck | output | 1 | Shift clock to the chain |
| sdo | output | 1 | Serial data to the first node |
| latch | output | 1 | Strobe that transfers shifted bits to node outputs |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |
| node_count | output | $clog2(MAX_NODES+1) | Nodes found by the last discover |
| timeout_err | output | 1 | Last discover saw no marker |
| stuck_err | output | 1 | Last discover found the sensed line not idle after flush |

## Verification
On every cycle the assertions check the local timing rules. These are that `sdo` stays still while `sck` is high, `sck` rests low when idle, `latch` and `done` are single-cycle pulses, the two error flags never appear together and always come with a zero count, data stays zero during the flush, and the result outputs move only at the end of a discover. The node count, the number of shift edges per operation, the per-node select levels, and the handling of ignored or colliding commands depend on what the chain sends back. Only the bench's scenarios can show these, because the bench models chains of different lengths, forces faults onto the sensed lines, and compares each operation's outcome against values derived from the requirements.

// File: rtl/daisy_pkg.sv
package daisy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FLUSH = 3'd1,
        ST_PROBE = 3'd2,
        ST_SHIFT = 3'd3,
        ST_LATCH = 3'd4
    } dm_state_e;

    typedef enum logic {
        SENSE_RETURN = 1'b0,
        SENSE_ACK    = 1'b1
    } dm_sense_e;

    typedef struct packed {
        logic timeout;
        logic stuck;
    } dm_flags_s;

    // Edge budget of the marker phase before a timeout is declared.
    function automatic int probe_limit(input int total_bits, input logic ack);
        return ack ? total_bits + 1 : total_bits;
    endfunction

endpackage

// File: rtl/daisy_sclk.sv
module daisy_sclk #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hold,
    output logic sck,
    output logic end_low,
    output logic end_high
);
    localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [TW-1:0] tcnt;
    logic          last;

    assign last     = (tcnt == TW'(HALF_DIV - 1));
    assign end_low  = run && !sck && last;
    assign end_high = run && sck && last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tcnt <= '0;
            sck  <= 1'b0;
        end else if (last) begin
            tcnt <= '0;
            if (!(hold && !sck)) sck <= ~sck;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/daisy_sync.sv
module daisy_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/daisy_pattern.sv
module daisy_pattern #(
    parameter int NODES     = 16,
    parameter int NODE_BITS = 2
) (
    input  logic [NODES-1:0]           sel,
    input  logic [NODES-1:0]           pol,
    output logic [NODES*NODE_BITS-1:0] bits
);
    // Node k occupies slice k; the MSB end (farthest node) is shifted first.
    for (genvar k = 0; k < NODES; k++) begin : g_node
        assign bits[k*NODE_BITS +: NODE_BITS] = {NODE_BITS{sel[k] ^ pol[k]}};
    end
endmodule

// File: rtl/daisy_master.sv
module daisy_master
    import daisy_pkg::*;
#(
    parameter int MAX_NODES = 16,
    parameter int NODE_BITS = 2,
    parameter int HALF_DIV  = 4,
    localparam int CW = $clog2(MAX_NODES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 disc_req,
    input  logic                 sel_req,
    input  logic                 ack_mode,
    input  logic [MAX_NODES-1:0] sel_pattern,
    input  logic [MAX_NODES-1:0] sel_polarity,
    input  logic                 ret_in,
    input  logic                 ack_in,
    output logic                 sck,
    output logic                 sdo,
    output logic                 latch,
    output logic                 busy,
    output logic                 done,
    output logic [CW-1:0]        node_count,
    output logic                 timeout_err,
    output logic                 stuck_err
);
    localparam int TOT       = MAX_NODES * NODE_BITS;
    localparam int FLUSH_LEN = TOT + 1;
    localparam int EW        = $clog2(TOT + 2) + 1;

    dm_state_e        state;
    dm_sense_e        mode_q;
    dm_flags_s        flags_q;
    logic [EW-1:0]    edges;
    logic [TOT-1:0]   shreg;
    logic [TOT-1:0]   pat_bits;
    logic [CW-1:0]    count_q;
    logic             sdo_q, done_q;
    logic             ret_s, ack_s, line;
    logic             run, hold, end_low, end_high;
    logic             hit, at_limit, idle_bad, flush_end, probe_end;
    logic [EW-1:0]    meas;

    daisy_sync u_sync_ret (.clk(clk), .rst(rst), .d(ret_in), .q(ret_s));
    daisy_sync u_sync_ack (.clk(clk), .rst(rst), .d(ack_in), .q(ack_s));

    daisy_pattern #(.NODES(MAX_NODES), .NODE_BITS(NODE_BITS)) u_pat (
        .sel(sel_pattern), .pol(sel_polarity), .bits(pat_bits)
    );

    daisy_sclk #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk(clk), .rst(rst), .run(run), .hold(hold),
        .sck(sck), .end_low(end_low), .end_high(end_high)
    );

    always_comb begin
        run       = (state == ST_FLUSH) || (state == ST_PROBE) || (state == ST_SHIFT);
        line      = (mode_q == SENSE_ACK) ? ack_s : ret_s;
        idle_bad  = (mode_q == SENSE_ACK) ? !line : line;
        hit       = (mode_q == SENSE_ACK) ? (line && edges != '0) : line;
        at_limit  = (edges == EW'(probe_limit(TOT, mode_q == SENSE_ACK)));
        flush_end = (state == ST_FLUSH) && (edges == EW'(FLUSH_LEN));
        probe_end = (state == ST_PROBE) && (hit || at_limit);
        hold      = end_low && (flush_end || probe_end);
        meas      = (mode_q == SENSE_ACK) ? edges - 1'b1 : edges;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            mode_q  <= SENSE_RETURN;
            flags_q <= '0;
            edges   <= '0;
            shreg   <= '0;
            count_q <= '0;
            sdo_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (disc_req) begin
                        mode_q <= dm_sense_e'(ack_mode);
                        edges  <= '0;
                        sdo_q  <= 1'b0;
                        state  <= ST_FLUSH;
                    end else if (sel_req) begin
                        shreg  <= pat_bits;
                        sdo_q  <= pat_bits[TOT-1];
                        edges  <= '0;
                        state  <= ST_SHIFT;
                    end
                end
                ST_FLUSH: begin
                    if (end_low && flush_end) begin
                        if (idle_bad) begin
                            flags_q <= '{timeout: 1'b0, stuck: 1'b1};
                            count_q <= '0;
                            done_q  <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            edges <= '0;
                            sdo_q <= 1'b1;
                            state <= ST_PROBE;
                        end
                    end else if (end_high) begin
                        edges <= edges + 1'b1;
                    end
                end
                ST_PROBE: begin
                    if (end_low && probe_end) begin
                        if (hit) begin
                            flags_q <= '0;
                            count_q <= CW'(meas / EW'(NODE_BITS));
                        end else begin
                            flags_q <= '{timeout: 1'b1, stuck: 1'b0};
                            count_q <= '0;
                        end
                        sdo_q  <= 1'b0;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (end_high) begin
                        edges <= edges + 1'b1;
                        if (mode_q == SENSE_ACK) sdo_q <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (end_high) begin
                        edges <= edges + 1'b1;
                        shreg <= shreg << 1;
                        if (edges == EW'(TOT - 1)) begin
                            sdo_q <= 1'b0;
                            state <= ST_LATCH;
                        end else begin
                            sdo_q <= shreg[TOT-2];
                        end
                    end
                end
                ST_LATCH: begin
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sdo         = sdo_q;
    assign latch       = (state == ST_LATCH);
    assign busy        = (state != ST_IDLE);
    assign done        = done_q;
    assign node_count  = count_q;
    assign timeout_err = flags_q.timeout;
    assign stuck_err   = flags_q.stuck;
endmodule

// File: rtl/daisy_master_chk.sv
module daisy_master_chk
    import daisy_pkg::*;
#(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          sck,
    input logic          sdo,
    input logic          latch,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] node_count,
    input logic          timeout_err,
    input logic          stuck_err,
    input dm_state_e     state
);
    AST_SDO_STILL_HIGH: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(sdo)); // R9
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck); // R9
    AST_LATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        latch |=> !latch); // R8
    AST_LATCH_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
        latch |-> !sck); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(timeout_err && stuck_err)); // R6
    AST_ERR_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (timeout_err || stuck_err) |-> node_count == '0); // R5
    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLUSH) |-> !sdo); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable({node_count, timeout_err, stuck_err}) |-> $past(busy)); // R11
endmodule

bind daisy_master daisy_master_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .sck(sck), .sdo(sdo), .latch(latch),
    .busy(busy), .done(done), .node_count(node_count),
    .timeout_err(timeout_err), .stuck_err(stuck_err), .state(state)
);

// File: tb/daisy_master_bench.sv
module daisy_master_bench;
    localparam int NN   = 16;
    localparam int NB   = 2;
    localparam int HD   = 4;
    localparam int TOT  = NN * NB;
    localparam int FL   = TOT + 1;
    localparam int CW   = $clog2(NN + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic disc_req = 1'b0, sel_req = 1'b0, ack_mode = 1'b0;
    logic [NN-1:0] sel_pattern = '0, sel_polarity = '0;
    logic ret_in, ack_in;
    logic sck, sdo, latch, busy, done, timeout_err, stuck_err;
    logic [CW-1:0] node_count;

    daisy_master #(.MAX_NODES(NN), .NODE_BITS(NB), .HALF_DIV(HD)) u_daisy_master (
        .clk(clk), .rst(rst), .disc_req(disc_req), .sel_req(sel_req),
        .ack_mode(ack_mode), .sel_pattern(sel_pattern), .sel_polarity(sel_polarity),
        .ret_in(ret_in), .ack_in(ack_in), .sck(sck), .sdo(sdo), .latch(latch),
        .busy(busy), .done(done), .node_count(node_count),
        .timeout_err(timeout_err), .stuck_err(stuck_err)
    );

    always #10 clk = ~clk;

    // Chain model
    int            chain_len = 0;
    logic [TOT-1:0] chain = '0;
    logic [NN-1:0]  nodes_q = '0;
    bit f_rhi = 0, f_rlo = 0, f_alo = 0;

    always @(posedge sck) chain <= {chain[TOT-2:0], sdo};
    always @(posedge latch) for (int k = 0; k < NN; k++) nodes_q[k] <= chain[k*NB];

    always @* begin
        logic r;
        logic any;
        if (chain_len == 0) r = sdo;
        else r = chain[chain_len*NB-1];
        any = 1'b0;
        for (int i = 0; i < TOT; i++) if (i < chain_len*NB && chain[i]) any = 1'b1;
        ret_in = f_rhi ? 1'b1 : (f_rlo ? 1'b0 : r);
        ack_in = f_alo ? 1'b0 : !any;
    end

    // Activity counters
    int cyc = 0, rises = 0, latches = 0, prev_rise = 0, last_per = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (latch) latches <= latches + 1;
    end
    always @(posedge sck) begin
        rises    <= rises + 1;
        last_per <= cyc - prev_rise;
        prev_rise <= cyc;
    end

    int total = 0, bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    typedef struct {
        string         req;
        bit            is_sel;
        int            count;
        bit            tmo;
        bit            stk;
        int            rises;
        int            latches;
        logic [NN-1:0] nodes;
        int            nlen;
    } exp_t;

    exp_t q[$];
    int last_cnt = 0;
    bit last_tmo = 0, last_stk = 0;

    // Monitor: pops one expectation per done pulse
    initial begin
        int rb = 0, lb = 0;
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                if (q.size() == 0) begin
                    check(0, "R10", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(int'(node_count) == e.count, e.req, "node_count", node_count, e.count);
                    check(timeout_err == e.tmo, e.req, "timeout_err", timeout_err, e.tmo);
                    check(stuck_err == e.stk, e.req, "stuck_err", stuck_err, e.stk);
                    check(rises - rb == e.rises, e.req, "sck rising edges", rises - rb, e.rises);
                    check(latches - lb == e.latches, "R8", "latch pulses", latches - lb, e.latches);
                    check(!busy, "R10", "busy at done", busy, 0);
                    if (e.is_sel) begin
                        check(last_per == 2*HD, "R9", "sck period", last_per, 2*HD);
                        for (int k = 0; k < e.nlen; k++)
                            check(nodes_q[k] == e.nodes[k], "R7", $sformatf("node %0d level", k),
                                  nodes_q[k], e.nodes[k]);
                    end
                end
                rb = rises;
                lb = latches;
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (!done);
        @(negedge clk);
    endtask

    task automatic run_disc(input bit am, input int len, input bit rhi, input bit rlo,
                            input bit alo, input int ecnt, input bit etmo, input bit estk,
                            input int erises, input string req, input bit stray_sel,
                            input bit both);
        exp_t e;
        chain_len = len; f_rhi = rhi; f_rlo = rlo; f_alo = alo;
        e.req = req; e.is_sel = 0; e.count = ecnt; e.tmo = etmo; e.stk = estk;
        e.rises = erises; e.latches = 0; e.nodes = '0; e.nlen = 0;
        q.push_back(e);
        ack_mode = am; disc_req = 1'b1; sel_req = both;
        @(negedge clk);
        disc_req = 1'b0; sel_req = 1'b0;
        check(busy, "R10", "busy after discover command", busy, 1);
        if (stray_sel) begin
            repeat (20) @(negedge clk);
            sel_req = 1'b1;
            @(negedge clk);
            sel_req = 1'b0;
        end
        wait_idle();
        last_cnt = ecnt; last_tmo = etmo; last_stk = estk;
        f_rhi = 0; f_rlo = 0; f_alo = 0;
    endtask

    task automatic run_sel(input logic [NN-1:0] pat, input logic [NN-1:0] pol,
                           input int len, input string req);
        exp_t e;
        chain_len = len;
        e.req = req; e.is_sel = 1; e.count = last_cnt; e.tmo = last_tmo; e.stk = last_stk;
        e.rises = TOT; e.latches = 1; e.nodes = pat ^ pol; e.nlen = len;
        q.push_back(e);
        sel_pattern = pat; sel_polarity = pol; sel_req = 1'b1;
        @(negedge clk);
        sel_req = 1'b0;
        wait_idle();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({sck, sdo, latch, busy, done} == 5'b0, "R1", "outputs in reset", {sck, sdo, latch, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(node_count == '0 && !timeout_err && !stuck_err, "R1", "results after reset",
              node_count, 0);
        check({sck, sdo, latch, busy, done} == 5'b0, "R1", "idle outputs", {sck, sdo, latch, busy, done}, 0);

        // R7 all nodes enabled, fills chain with ones
        run_sel({NN{1'b1}}, '0, NN, "R7");
        // R2 flush must clear the ones before the return count
        run_disc(0, NN, 0, 0, 0, NN, 0, 0, FL + NN*NB, "R2", 0, 0);
        run_disc(0, 0, 0, 0, 0, 0, 0, 0, FL, "R3", 0, 0);
        run_disc(0, 1, 0, 0, 0, 1, 0, 0, FL + NB, "R3", 0, 0);
        run_disc(0, 5, 0, 0, 0, 5, 0, 0, FL + 5*NB, "R3", 0, 0);
        // R4 acknowledge mode
        run_disc(1, 0, 0, 0, 0, 0, 0, 0, FL + 1, "R4", 0, 0);
        run_disc(1, 3, 0, 0, 0, 3, 0, 0, FL + 3*NB + 1, "R4", 0, 0);
        run_disc(1, NN, 0, 0, 0, NN, 0, 0, FL + NN*NB + 1, "R4", 0, 0);
        // R5 stuck lines
        run_disc(0, 4, 1, 0, 0, 0, 0, 1, FL, "R5", 0, 0);
        run_disc(1, 4, 0, 0, 1, 0, 0, 1, FL, "R5", 0, 0);
        // R6 marker never returns
        run_disc(0, 4, 0, 1, 0, 0, 1, 0, FL + TOT, "R6", 0, 0);
        // R10 stray select while busy is ignored; simultaneous commands favour discover
        run_disc(0, 4, 0, 0, 0, 4, 0, 0, FL + 4*NB, "R10", 1, 0);
        repeat (5) @(negedge clk);
        check(!busy && !sck, "R10", "no operation after stray select", busy, 0);
        run_disc(1, 4, 0, 0, 0, 4, 0, 0, FL + 4*NB + 1, "R10", 0, 1);
        // R7/R8/R11 select patterns with mixed polarity; results must persist
        run_sel(16'h0004, 16'h0000, 4, "R11");
        run_sel(16'h000A, 16'h0003, 4, "R11");
        check(int'(node_count) == 4 && !timeout_err && !stuck_err, "R11",
              "count kept after selects", node_count, 4);

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R10", "pending expectations", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule